// File: doc/BRIEF.md
# DMA Address Sequencing Unit

This block turns one DMA descriptor into the stream of per-beat read and write addresses for a single channel. A descriptor carries a source base, a destination base, a byte count, a beat size code and an address mode. The unit accepts the descriptor through a valid/ready handshake. It then presents one beat at a time on a second valid/ready handshake, moving to the next beat only when the consumer accepts the current one.

Four address modes are supported:
- **Copy:** both addresses walk upward.
- **Reverse:** the destination walks upward while the source walks downward from the top of its region, so the bytes land in reverse order.
- **Fixed port:** the destination stays pinned to one granularity-aligned address, which suits a memory-mapped FIFO.
- **Fill:** the destination region is written with no source read, and a fill flag marks every beat.

The unit moves no data and fetches no descriptors. It produces the address sequence, a last-beat marker, a one-cycle completion pulse, and a one-cycle error pulse for a byte count that the beat size does not divide.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset, `beat_valid`, `xfer_done` and `len_err` are low and `desc_ready` is high.
- R2: `desc_gran` code g selects a beat size of 2^g bytes (0→1, 1→2, 2→4, 3→8). A legal descriptor yields exactly `desc_len`/2^g beats. `beat_last` is high on the final beat only.
- R3: With `desc_mode` = 0 (copy), beat k reads `src + k*step` and writes `dst + k*step`, where step is the beat size. Addresses wrap modulo 2^ADDR_W.
- R4: With `desc_mode` = 1 (reverse), beat k reads `src + len - step - k*step` and writes `dst + k*step`.
- R5: With `desc_mode` = 2 (fixed port), every beat writes `dst` with its low g bits cleared, and beat k reads `src + k*step`.
- R6: With `desc_mode` = 3 (fill), every beat has `beat_fill` high and `beat_rd_addr` zero, and beat k writes `dst + k*step`. In every other mode `beat_fill` is low.
- R7: A beat that is valid but not accepted stays valid, and its addresses stay unchanged, in the following cycle.
- R8: `xfer_done` is high for exactly one cycle: the cycle after the final beat is accepted. `desc_ready` is high again in the cycle after that.
- R9: A nonzero `desc_len` with any of its low g bits set raises `len_err` for one cycle, the cycle after acceptance. No beat is issued and `xfer_done` stays low.
- R10: A zero `desc_len` issues no beats and raises `xfer_done` in the cycle after acceptance.
- R11: `desc_ready` is low while a transfer is in progress. A descriptor offered during that time is ignored and does not alter the running beat sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Unit idle, descriptor can be taken |
| desc_src | input | ADDR_W | Source base address |
| desc_dst | input | ADDR_W | Destination base address |
| desc_len | input | LEN_W | Transfer length in bytes |
| desc_gran | input | 2 | Beat size code, 2^code bytes |
| desc_mode | input | 2 | 0 copy, 1 reverse, 2 fixed port, 3 fill |
| beat_valid | output | 1 | Beat addresses valid |
| beat_ready | input | 1 | Consumer accepts the beat |
| beat_rd_addr | output | ADDR_W | Read address of the beat |
| beat_wr_addr | output | ADDR_W | Write address of the beat |
| beat_fill | output | 1 | Beat writes without a read |
| beat_last | output | 1 | Final beat of the transfer |
| xfer_done | output | 1 | One-cycle completion pulse |
| len_err | output | 1 | One-cycle illegal-length pulse |

## Verification
The bench builds the unit with ADDR_W = 16 and LEN_W = 8. With these sizes, source bases near the top of the address space make the wrap of both walking directions reachable within a few beats. The bench sweeps all four modes against all four beat sizes, with lengths of zero to four beats, plus a misaligned length for every beat size above one byte. Each run uses a different consumer stall pattern and offers junk descriptors throughout. Expected addresses come from the closed-form expressions in the requirements.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        MODE_COPY   = 2'd0,
        MODE_REV    = 2'd1,
        MODE_FIXDST = 2'd2,
        MODE_FILL   = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_st_e;

    typedef enum logic [1:0] {
        DIR_INC  = 2'd0,
        DIR_DEC  = 2'd1,
        DIR_HOLD = 2'd2
    } step_dir_e;

    localparam int STEP_W = 4;

endpackage

// File: rtl/dma_seq_decode.sv
module dma_seq_decode
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic [ADDR_W-1:0] src_i,
    input  logic [ADDR_W-1:0] dst_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [1:0]        gran_i,
    input  logic [1:0]        mode_i,
    output logic [STEP_W-1:0] step_o,
    output logic              len_bad_o,
    output logic              len_zero_o,
    output logic [ADDR_W-1:0] src_start_o,
    output logic [ADDR_W-1:0] dst_start_o,
    output step_dir_e         src_dir_o,
    output step_dir_e         dst_dir_o,
    output logic              fill_o
);

    logic [ADDR_W-1:0] mask_a;
    logic [LEN_W-1:0]  mask_l;

    always_comb begin
        step_o     = STEP_W'(1) << gran_i;
        mask_a     = ADDR_W'(step_o) - ADDR_W'(1);
        mask_l     = LEN_W'(step_o) - LEN_W'(1);
        len_zero_o = (len_i == '0);
        len_bad_o  = |(len_i & mask_l);
        fill_o     = 1'b0;
        src_start_o = src_i;
        dst_start_o = dst_i;
        src_dir_o   = DIR_INC;
        dst_dir_o   = DIR_INC;
        case (xfer_mode_e'(mode_i))
            MODE_REV: begin
                src_start_o = src_i + ADDR_W'(len_i) - ADDR_W'(step_o);
                src_dir_o   = DIR_DEC;
            end
            MODE_FIXDST: begin
                dst_start_o = dst_i & ~mask_a;
                dst_dir_o   = DIR_HOLD;
            end
            MODE_FILL: begin
                src_start_o = '0;
                src_dir_o   = DIR_HOLD;
                fill_o      = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dma_seq_step.sv
module dma_seq_step
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [STEP_W-1:0] step_i,
    input  step_dir_e         dir_i,
    output logic [ADDR_W-1:0] addr_o
);

    always_comb begin
        case (dir_i)
            DIR_INC: addr_o = addr_i + ADDR_W'(step_i);
            DIR_DEC: addr_o = addr_i - ADDR_W'(step_i);
            default: addr_o = addr_i;
        endcase
    end

endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [ADDR_W-1:0] desc_src,
    input  logic [ADDR_W-1:0] desc_dst,
    input  logic [LEN_W-1:0]  desc_len,
    input  logic [1:0]        desc_gran,
    input  logic [1:0]        desc_mode,
    output logic              beat_valid,
    input  logic              beat_ready,
    output logic [ADDR_W-1:0] beat_rd_addr,
    output logic [ADDR_W-1:0] beat_wr_addr,
    output logic              beat_fill,
    output logic              beat_last,
    output logic              xfer_done,
    output logic              len_err
);

    typedef struct packed {
        seq_st_e           st;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [LEN_W-1:0]  rem;
        logic [STEP_W-1:0] step;
        step_dir_e         src_dir;
        step_dir_e         dst_dir;
        logic              fill;
        logic              err;
    } seq_state_t;

    seq_state_t s_d, s_q;

    logic [STEP_W-1:0] dec_step;
    logic              dec_bad, dec_zero, dec_fill;
    logic [ADDR_W-1:0] dec_src, dec_dst;
    step_dir_e         dec_src_dir, dec_dst_dir;
    logic [ADDR_W-1:0] src_nxt, dst_nxt;
    logic              fire;

    dma_seq_decode #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) decode_i (
        .src_i       (desc_src),
        .dst_i       (desc_dst),
        .len_i       (desc_len),
        .gran_i      (desc_gran),
        .mode_i      (desc_mode),
        .step_o      (dec_step),
        .len_bad_o   (dec_bad),
        .len_zero_o  (dec_zero),
        .src_start_o (dec_src),
        .dst_start_o (dec_dst),
        .src_dir_o   (dec_src_dir),
        .dst_dir_o   (dec_dst_dir),
        .fill_o      (dec_fill)
    );

    dma_seq_step #(.ADDR_W(ADDR_W)) src_step_i (
        .addr_i (s_q.src),
        .step_i (s_q.step),
        .dir_i  (s_q.src_dir),
        .addr_o (src_nxt)
    );

    dma_seq_step #(.ADDR_W(ADDR_W)) dst_step_i (
        .addr_i (s_q.dst),
        .step_i (s_q.step),
        .dir_i  (s_q.dst_dir),
        .addr_o (dst_nxt)
    );

    always_comb begin
        desc_ready   = (s_q.st == ST_IDLE);
        beat_valid   = (s_q.st == ST_RUN);
        beat_rd_addr = s_q.src;
        beat_wr_addr = s_q.dst;
        beat_fill    = s_q.fill;
        beat_last    = beat_valid && (s_q.rem == LEN_W'(s_q.step));
        xfer_done    = (s_q.st == ST_FIN) && !s_q.err;
        len_err      = (s_q.st == ST_FIN) && s_q.err;
        fire         = beat_valid && beat_ready;

        s_d = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (desc_valid) begin
                    s_d.src     = dec_src;
                    s_d.dst     = dec_dst;
                    s_d.rem     = desc_len;
                    s_d.step    = dec_step;
                    s_d.src_dir = dec_src_dir;
                    s_d.dst_dir = dec_dst_dir;
                    s_d.fill    = dec_fill;
                    s_d.err     = dec_bad;
                    s_d.st      = (dec_bad || dec_zero) ? ST_FIN : ST_RUN;
                end
            end
            ST_RUN: begin
                if (fire) begin
                    s_d.src = src_nxt;
                    s_d.dst = dst_nxt;
                    s_d.rem = s_q.rem - LEN_W'(s_q.step);
                    if (beat_last) s_d.st = ST_FIN;
                end
            end
            default: begin
                s_d.st  = ST_IDLE;
                s_d.err = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, src: '0, dst: '0, rem: '0, step: '0,
                     src_dir: DIR_INC, dst_dir: DIR_INC, fill: 1'b0, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> desc_ready && !beat_valid && !xfer_done && !len_err);

    assert_last_then_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_ready && beat_last |=> !beat_valid && xfer_done);

    assert_rev_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_ready && !beat_last && s_q.src_dir == DIR_DEC
        |=> beat_rd_addr == $past(beat_rd_addr) - ADDR_W'($past(s_q.step)));

    assert_fixed_dst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_ready && !beat_last && s_q.dst_dir == DIR_HOLD
        |=> $stable(beat_wr_addr));

    assert_fill_no_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_fill |-> beat_rd_addr == '0);

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !beat_ready
        |=> beat_valid && $stable(beat_rd_addr) && $stable(beat_wr_addr));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done && desc_ready);

    assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> !xfer_done && !beat_valid ##1 !len_err && desc_ready);

    assert_busy_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(desc_ready && beat_valid));

endmodule

// File: tb/dma_addr_seq_tb_top.sv
module dma_addr_seq_tb_top;

    localparam int ADDR_W = 16;
    localparam int LEN_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              desc_valid = 1'b0;
    logic              desc_ready;
    logic [ADDR_W-1:0] desc_src = '0;
    logic [ADDR_W-1:0] desc_dst = '0;
    logic [LEN_W-1:0]  desc_len = '0;
    logic [1:0]        desc_gran = '0;
    logic [1:0]        desc_mode = '0;
    logic              beat_valid;
    logic              beat_ready = 1'b0;
    logic [ADDR_W-1:0] beat_rd_addr;
    logic [ADDR_W-1:0] beat_wr_addr;
    logic              beat_fill;
    logic              beat_last;
    logic              xfer_done;
    logic              len_err;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit ended = 1'b0;

    always #4 clk = ~clk;

    dma_addr_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .desc_valid   (desc_valid),
        .desc_ready   (desc_ready),
        .desc_src     (desc_src),
        .desc_dst     (desc_dst),
        .desc_len     (desc_len),
        .desc_gran    (desc_gran),
        .desc_mode    (desc_mode),
        .beat_valid   (beat_valid),
        .beat_ready   (beat_ready),
        .beat_rd_addr (beat_rd_addr),
        .beat_wr_addr (beat_wr_addr),
        .beat_fill    (beat_fill),
        .beat_last    (beat_last),
        .xfer_done    (xfer_done),
        .len_err      (len_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_up();
        end
    end

    task automatic run_desc(input int m, input int g, input int nb, input bit bad, input int seed);
        int step, len, k, exp_nb;
        bit fin;
        logic [ADDR_W-1:0] src, dst, er, ew;
        step   = 1 << g;
        len    = bad ? nb * step + 1 : nb * step;
        exp_nb = bad ? 0 : nb;
        src    = ADDR_W'(16'hFFF0 + seed * 37);
        dst    = ADDR_W'(16'h2003 + seed * 11);
        @(negedge clk);
        chk(desc_ready === 1'b1, "R8 ready before descriptor", int'(desc_ready), 1);
        desc_valid = 1'b1;
        desc_src   = src;
        desc_dst   = dst;
        desc_len   = LEN_W'(len);
        desc_gran  = 2'(g);
        desc_mode  = 2'(m);
        @(posedge clk);
        @(negedge clk);
        desc_src  = ~src;
        desc_dst  = ~dst;
        desc_len  = 8'd3;
        desc_mode = 2'(m + 1);
        k   = 0;
        fin = 1'b0;
        for (int c = 0; c < 400 && !fin; c++) begin
            beat_ready = ((c + seed) % 3) != 0 || (seed % 5 == 0);
            #1;
            if (beat_valid) begin
                chk(desc_ready === 1'b0, "R11 ready low while busy", int'(desc_ready), 0);
                chk(k < exp_nb, "R2 beat count", k, exp_nb);
                case (m)
                    1:       er = src + ADDR_W'(len - step - k * step);
                    3:       er = '0;
                    default: er = src + ADDR_W'(k * step);
                endcase
                ew = (m == 2) ? (dst & ~ADDR_W'(step - 1)) : dst + ADDR_W'(k * step);
                if (m == 0) begin
                    chk(beat_rd_addr === er, "R3 copy rd", int'(beat_rd_addr), int'(er));
                    chk(beat_wr_addr === ew, "R3 copy wr", int'(beat_wr_addr), int'(ew));
                end else if (m == 1) begin
                    chk(beat_rd_addr === er, "R4 reverse rd", int'(beat_rd_addr), int'(er));
                    chk(beat_wr_addr === ew, "R4 reverse wr", int'(beat_wr_addr), int'(ew));
                end else if (m == 2) begin
                    chk(beat_rd_addr === er, "R5 fixed rd", int'(beat_rd_addr), int'(er));
                    chk(beat_wr_addr === ew, "R5 fixed wr", int'(beat_wr_addr), int'(ew));
                end else begin
                    chk(beat_rd_addr === er, "R6 fill rd", int'(beat_rd_addr), int'(er));
                    chk(beat_wr_addr === ew, "R6 fill wr", int'(beat_wr_addr), int'(ew));
                end
                chk(beat_fill === (m == 3), "R6 fill flag", int'(beat_fill), int'(m == 3));
                chk(beat_last === (k == exp_nb - 1), "R2 last flag", int'(beat_last), int'(k == exp_nb - 1));
                chk(!xfer_done && !len_err, "R8 no pulse during beats", int'(xfer_done), 0);
                if (beat_ready) k++;
            end else if (xfer_done || len_err) begin
                desc_valid = 1'b0;
                fin = 1'b1;
                if (bad) begin
                    chk(len_err === 1'b1 && xfer_done === 1'b0, "R9 error pulse", int'(len_err), 1);
                    chk(k == 0, "R9 no beats", k, 0);
                end else begin
                    chk(xfer_done === 1'b1 && len_err === 1'b0, "R8 done pulse", int'(xfer_done), 1);
                    if (nb == 0) chk(k == 0, "R10 zero length no beats", k, 0);
                    else         chk(k == exp_nb, "R2 beats issued", k, exp_nb);
                end
            end else begin
                chk(1'b0, "R8 idle gap inside transfer", 0, 1);
                desc_valid = 1'b0;
                fin = 1'b1;
            end
            if (!fin) @(negedge clk);
        end
        chk(fin, "R8 transfer finished", int'(fin), 1);
        beat_ready = 1'b0;
        @(negedge clk);
        chk(xfer_done === 1'b0 && len_err === 1'b0, "R8 single-cycle pulse", int'(xfer_done), 0);
        chk(desc_ready === 1'b1, "R8 ready after finish", int'(desc_ready), 1);
    endtask

    task automatic stall_check();
        logic [ADDR_W-1:0] r0, w0;
        @(negedge clk);
        desc_valid = 1'b1;
        desc_src   = 16'h0100;
        desc_dst   = 16'h0200;
        desc_len   = 8'd16;
        desc_gran  = 2'd2;
        desc_mode  = 2'd0;
        beat_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        desc_valid = 1'b0;
        r0 = beat_rd_addr;
        w0 = beat_wr_addr;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(beat_valid === 1'b1, "R7 valid held", int'(beat_valid), 1);
            chk(beat_rd_addr === r0 && beat_wr_addr === w0, "R7 addr held",
                int'(beat_rd_addr), int'(r0));
        end
        beat_ready = 1'b1;
        for (int i = 0; i < 4; i++) @(negedge clk);
        chk(xfer_done === 1'b1, "R8 done after stalled run", int'(xfer_done), 1);
        beat_ready = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #1;
        chk(desc_ready === 1'b1 && beat_valid === 1'b0, "R1 ready during reset", int'(desc_ready), 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(desc_ready === 1'b1, "R1 desc_ready", int'(desc_ready), 1);
        chk(beat_valid === 1'b0, "R1 beat_valid", int'(beat_valid), 0);
        chk(xfer_done === 1'b0 && len_err === 1'b0, "R1 pulses low", int'(xfer_done), 0);
        stall_check();
        for (int m = 0; m < 4; m++) begin
            for (int g = 0; g < 4; g++) begin
                for (int nb = 0; nb <= 4; nb++) begin
                    run_desc(m, g, nb, 1'b0, m * 20 + g * 5 + nb);
                end
                if (g > 0) run_desc(m, g, 2, 1'b1, m * 7 + g);
            end
        end
        finish_up();
    end

endmodule